// File: doc/BRIEF.md
# Partitioned SIMD Magnitude Comparator

This block compares two 16-bit unsigned operands in a single combinational step. A 3-bit split vector divides the operands into lanes. Each split bit cuts the operands at one nibble boundary, so the operands can be treated as one 16-bit value, as several lanes of mixed width, or as four independent 4-bit values. The split vector can change from one cycle to the next.

For every lane the block reports three results: A equal to B, A greater than B, and A greater than or equal to B. Each result is a 4-bit vector. The bit for a lane sits at the index of that lane's lowest nibble. Bits at the indices of a lane's upper nibbles are always 0. A datapath that runs the same compare at several element sizes can use one instance of this block for all of them.

Top module: `simd_part_cmp`

## Requirements
- R1: Operands are 16 bits wide, the split vector is 3 bits wide and each result vector is 4 bits wide. Split bit k, when set, cuts the operands between bit 4k+3 and bit 4k+4, so it cuts at bit 4, bit 8 or bit 12.
- R2: With split = 3'b000 the operands compare as one 16-bit lane, the result appears on bit 0, and bits 3:1 of every result vector are 0.
- R3: With split = 3'b010 there are two 8-bit lanes, made of bits 7:0 and bits 15:8. Their results appear on bits 0 and 2, and bits 1 and 3 are 0.
- R4: With split = 3'b111 there are four 4-bit lanes, and the result for nibble n appears on bit n.
- R5: For any split value, a lane's result bit sits at the index of the lane's lowest nibble, and every other bit of every result vector is 0.
- R6: The equal vector bit for a lane is 1 exactly when the lane's A and B fields are identical.
- R7: The greater vector bit for a lane is 1 exactly when the lane's A field, read as unsigned, exceeds its B field. The most significant differing nibble in the lane decides the result.
- R8: In every bit position, the greater-or-equal vector equals the greater vector ORed with the equal vector.
- R9: When A and B are identical, every lane reports equal and greater-or-equal as 1, and greater as 0.
- R10: The results of a lane do not depend on operand bits outside that lane.
- R11: The block has no clock or state. Its outputs follow any change of the operands or of the split vector with no clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 16 | Operand A, unsigned |
| opb_i | input | 16 | Operand B, unsigned |
| split_i | input | 3 | Lane cut enables; bit k cuts at bit 4(k+1) |
| eq_o | output | 4 | Per-lane A == B at each lane's lowest nibble index |
| gt_o | output | 4 | Per-lane A > B at each lane's lowest nibble index |
| ge_o | output | 4 | Per-lane A >= B at each lane's lowest nibble index |

## Verification
The hardest case to reach is a lane wider than one nibble whose top nibble is equal in A and B while a lower nibble differs. Only that case tests whether the equal/greater information passes correctly across a nibble boundary that is not cut. Operand nibbles are drawn from a small value set that includes equal, adjacent and extreme codes, so neighbouring nibbles are often equal and the lower nibbles decide the result. This stimulus runs under all eight split values, and the expected results are computed from integer lane fields. Directed cases cover identical operands, a difference confined to one lane, and a split that changes while the operands are held.

// File: rtl/pcmp_pkg.sv
package pcmp_pkg;
  typedef struct packed {
    logic eq;
    logic gt;
    logic ge;
  } cmp_flags_t;
endpackage

// File: rtl/pcmp_nibble.sv
module pcmp_nibble
  import pcmp_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic [NIB_W-1:0] a_i,
  input  logic [NIB_W-1:0] b_i,
  output cmp_flags_t       flags_o
);
  always_comb begin
    flags_o.eq = (a_i == b_i);
    flags_o.gt = (a_i >  b_i);
    flags_o.ge = (a_i >= b_i);
  end
endmodule

// File: rtl/pcmp_chain.sv
module pcmp_chain
  import pcmp_pkg::*;
#(
  parameter int NUM_NIB = 4,
  localparam int SPLIT_W = (NUM_NIB > 1) ? NUM_NIB - 1 : 1
) (
  input  cmp_flags_t [NUM_NIB-1:0] nib_i,
  input  logic [SPLIT_W-1:0]       split_i,
  output cmp_flags_t [NUM_NIB-1:0] acc_o
);
  // acc_o[i] holds the running result from the lane's top nibble down to nibble i
  for (genvar i = 0; i < NUM_NIB; i++) begin : g_link
    if (i == NUM_NIB - 1) begin : g_top
      assign acc_o[i] = nib_i[i];
    end else begin : g_mid
      logic cut;
      assign cut = split_i[i];
      always_comb begin
        if (cut) begin
          acc_o[i] = nib_i[i];
        end else begin
          acc_o[i].eq = acc_o[i+1].eq & nib_i[i].eq;
          acc_o[i].gt = acc_o[i+1].gt | (acc_o[i+1].eq & nib_i[i].gt);
          acc_o[i].ge = acc_o[i+1].gt | (acc_o[i+1].eq & nib_i[i].ge);
        end
      end
    end
  end

  if (NUM_NIB > 1) begin : g_chk
    always_comb begin
      if (&split_i) begin
        AST_FULL_SPLIT_LOCAL: assert (acc_o == nib_i) // R4
          else $error("fully split chain differs from nibble flags");
      end
    end
  end
endmodule

// File: rtl/pcmp_pack.sv
module pcmp_pack
  import pcmp_pkg::*;
#(
  parameter int NUM_NIB = 4,
  localparam int SPLIT_W = (NUM_NIB > 1) ? NUM_NIB - 1 : 1
) (
  input  cmp_flags_t [NUM_NIB-1:0] acc_i,
  input  logic [SPLIT_W-1:0]       split_i,
  output logic [NUM_NIB-1:0]       eq_o,
  output logic [NUM_NIB-1:0]       gt_o,
  output logic [NUM_NIB-1:0]       ge_o
);
  logic [NUM_NIB-1:0] lane_base;

  for (genvar i = 0; i < NUM_NIB; i++) begin : g_out
    if (i == 0) begin : g_low
      assign lane_base[i] = 1'b1;
    end else begin : g_up
      assign lane_base[i] = split_i[i-1];
    end
    assign eq_o[i] = lane_base[i] & acc_i[i].eq;
    assign gt_o[i] = lane_base[i] & acc_i[i].gt;
    assign ge_o[i] = lane_base[i] & acc_i[i].ge;
  end

  always_comb begin
    AST_GE_IS_GT_OR_EQ: assert (ge_o == (gt_o | eq_o)) // R8
      else $error("ge differs from gt|eq");
    AST_EQ_GT_EXCLUSIVE: assert ((eq_o & gt_o) == '0) // R7
      else $error("eq and gt both set");
  end
endmodule

// File: rtl/simd_part_cmp.sv
module simd_part_cmp
  import pcmp_pkg::*;
#(
  parameter int NIB_W   = 4,
  parameter int NUM_NIB = 4,
  localparam int DATA_W  = NIB_W * NUM_NIB,
  localparam int SPLIT_W = (NUM_NIB > 1) ? NUM_NIB - 1 : 1
) (
  input  logic [DATA_W-1:0]  opa_i,
  input  logic [DATA_W-1:0]  opb_i,
  input  logic [SPLIT_W-1:0] split_i,
  output logic [NUM_NIB-1:0] eq_o,
  output logic [NUM_NIB-1:0] gt_o,
  output logic [NUM_NIB-1:0] ge_o
);
  cmp_flags_t [NUM_NIB-1:0] nib_flags;
  cmp_flags_t [NUM_NIB-1:0] acc_flags;

  for (genvar n = 0; n < NUM_NIB; n++) begin : g_nib
    pcmp_nibble #(.NIB_W(NIB_W)) u_nib (
      .a_i     (opa_i[n*NIB_W +: NIB_W]),
      .b_i     (opb_i[n*NIB_W +: NIB_W]),
      .flags_o (nib_flags[n])
    );
  end

  pcmp_chain #(.NUM_NIB(NUM_NIB)) u_chain (
    .nib_i   (nib_flags),
    .split_i (split_i),
    .acc_o   (acc_flags)
  );

  pcmp_pack #(.NUM_NIB(NUM_NIB)) u_pack (
    .acc_i   (acc_flags),
    .split_i (split_i),
    .eq_o    (eq_o),
    .gt_o    (gt_o),
    .ge_o    (ge_o)
  );

  // positions that do not start a lane must stay quiet
  logic [NUM_NIB-1:0] quiet_pos;
  if (NUM_NIB > 1) begin : g_quiet
    assign quiet_pos = ~{split_i, 1'b1};
  end else begin : g_single
    assign quiet_pos = '0;
  end

  always_comb begin
    AST_UPPER_NIBBLES_ZERO: assert (((eq_o | gt_o | ge_o) & quiet_pos) == '0) // R5
      else $error("result bit outside lane base");
  end
endmodule

// File: tb/tb_simd_part_cmp.sv
module tb_simd_part_cmp;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 100000;

  logic        clk;
  logic [15:0] opa, opb;
  logic [2:0]  split;
  logic [3:0]  eq_o, gt_o, ge_o;
  int checks;
  int fails;
  bit done;

  simd_part_cmp dut (
    .opa_i(opa), .opb_i(opb), .split_i(split),
    .eq_o(eq_o), .gt_o(gt_o), .ge_o(ge_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // kind: 0 eq, 1 gt, 2 ge; lanes end at nibble 3 or where split[n] is set
  function automatic logic [3:0] model(input logic [15:0] a, input logic [15:0] b,
                                       input logic [2:0] m, input int kind);
    logic [3:0] r;
    int base;
    r = '0;
    base = 0;
    for (int n = 0; n < 4; n++) begin
      if (n == 3 || m[n]) begin
        int w;
        int av;
        int bv;
        bit hit;
        w  = 4 * (n - base + 1);
        av = int'(a >> (4*base)) & ((1 << w) - 1);
        bv = int'(b >> (4*base)) & ((1 << w) - 1);
        hit = (kind == 0) ? (av == bv) : (kind == 1) ? (av > bv) : (av >= bv);
        r[base] = hit;
        base = n + 1;
      end
    end
    return r;
  endfunction

  function automatic logic [3:0] nv(input int k);
    case (k)
      0: return 4'h0;
      1: return 4'h7;
      2: return 4'h8;
      default: return 4'hF;
    endcase
  endfunction

  function automatic logic [15:0] word_of(input int idx);
    return {nv((idx >> 6) & 3), nv((idx >> 4) & 3), nv((idx >> 2) & 3), nv(idx & 3)};
  endfunction

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s a=%h b=%h split=%b actual=%b expected=%b",
               tag, opa, opb, split, act, exp);
    end
  endtask

  task automatic apply_and_check(input logic [15:0] a, input logic [15:0] b,
                                 input logic [2:0] m, input string tag);
    opa = a; opb = b; split = m;
    #1;
    chk({tag, " R6 eq"}, eq_o, model(a, b, m, 0));
    chk({tag, " R7 gt"}, gt_o, model(a, b, m, 1));
    chk({tag, " R8 ge"}, ge_o, model(a, b, m, 2));
  endtask

  function automatic string split_tag(input logic [2:0] m);
    case (m)
      3'b000:  return "R2";
      3'b010:  return "R3";
      3'b111:  return "R4";
      default: return "R5";
    endcase
  endfunction

  initial begin
    checks = 0; fails = 0; done = 0;
    opa = '0; opb = '0; split = '0;
    #1;
    // initial state with zero inputs: single lane, equal
    chk("R2 initial eq", eq_o, 4'b0001);
    chk("R2 initial gt", gt_o, 4'b0000);
    chk("R2 initial ge", ge_o, 4'b0001);

    // R1: cut at bit 4 only
    apply_and_check(16'h0010, 16'h0001, 3'b001, "R1");
    chk("R1 gt position", gt_o, 4'b0010);

    // R9: identical operands under every split
    for (int m = 0; m < 8; m++) begin
      opa = 16'hABCD; opb = 16'hABCD; split = 3'(m);
      #1;
      chk("R9 eq", eq_o, {split, 1'b1});
      chk("R9 gt", gt_o, 4'b0000);
      chk("R9 ge", ge_o, {split, 1'b1});
    end

    // R10: difference confined to the top lane
    apply_and_check(16'h5123, 16'h4123, 3'b111, "R10");
    chk("R10 low lanes eq", eq_o, 4'b0111);
    apply_and_check(16'h1200, 16'h1234, 3'b010, "R10");
    chk("R10 upper lane eq", eq_o, 4'b0100);

    // R7: top nibble equal, lower nibble decides in wide lane
    apply_and_check(16'h7F80, 16'h7F7F, 3'b000, "R7");
    chk("R7 borrow across nibbles", gt_o, 4'b0001);

    // R11: split changes, operands held, no clock edge awaited
    opa = 16'h00F0; opb = 16'h0F00;
    split = 3'b000; #1;
    chk("R11 single lane gt", gt_o, 4'b0000);
    split = 3'b111; #1;
    chk("R11 resplit gt", gt_o, 4'b0010);

    // sweep: every split, structured operand set
    for (int m = 0; m < 8; m++) begin
      for (int ai = 0; ai < 256; ai++) begin
        for (int bi = ai % 9; bi < 256; bi += 9) begin
          apply_and_check(word_of(ai), word_of(bi), 3'(m), split_tag(3'(m)));
        end
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule